// File: doc/BRIEF.md
# Serial NVSRAM Command Frame Decoder

This block is a passive monitor for a SPI link to a small serial nonvolatile static RAM. An upstream deserializer hands it whole bytes: a strobe together with the byte shifted out on MOSI and the byte shifted in on MISO, along with the chip-select-active level. The monitor never drives the bus. It groups the bytes between a chip-select assertion and the matching release into one transaction and reports each transaction as a single decoded record.

The first byte of a frame is the command. The monitor masks it to get the opcode and takes a 4-bit word address from its middle bits. Every later byte is shifted into two 16-bit accumulators, one for each direction. When chip select is released, the monitor picks the value that belongs to the opcode: the device's reply for a read, the host's data for a write, and zero for any other opcode. It then pulses a record-valid output for one cycle. With that pulse come the opcode, the address, the value, a saturating byte count, a flag that marks a frame holding only the command, and a flag that marks a command byte whose top bit is clear.

Top module: `nvsram_frame_mon`

## Requirements
- R1: A frame opens only on a low-to-high change of `cs_active` that is seen after reset. The cycle in which it opens clears the byte count and both accumulators.
- R2: A `byte_vld` strobe that arrives while `cs_active` is low has no effect on any later record.
- R3: `rec_opcode` equals the command byte ANDed with 0x87. `rec_bad_op` is 1 exactly when bit 7 of the command byte is 0.
- R4: For a frame of two or more bytes, `rec_addr` equals bits 6:3 of the command byte.
- R5: Data bytes are shifted in with the most significant byte first, and only the last 16 bits are kept. A single data byte gives the value {0x00, byte}.
- R6: A frame of exactly one byte gives `rec_simple`=1, `rec_addr`=0, `rec_value`=0 and `rec_count`=1. A frame of two or more bytes gives `rec_simple`=0.
- R7: For a frame of two or more bytes with bit 7 of the command set, `rec_value` is the MISO accumulator when the low three opcode bits are 6 or 7 (read), the MOSI accumulator when they are 3 (write), and 0 otherwise. When bit 7 of the command is clear, the value is 0.
- R8: `rec_vld` is high for exactly one cycle, in the cycle after the clock edge at which `cs_active` is first sampled low, and the record fields hold their values until the next record.
- R9: `rec_count` is the number of bytes in the frame, command included, and it saturates at 255.
- R10: A frame that holds no bytes produces no record.
- R11: Synchronous active-high `rst` clears every output to 0 and drops any frame in progress. That frame produces no record, even if its bytes continue after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_active | input | 1 | Chip select asserted on the monitored link |
| byte_vld | input | 1 | One-cycle strobe: a byte pair was captured |
| mosi_byte | input | 8 | Byte sent from host to memory |
| miso_byte | input | 8 | Byte sent from memory to host |
| rec_vld | output | 1 | One-cycle record pulse |
| rec_opcode | output | 8 | Masked command opcode |
| rec_addr | output | 4 | Word address from the command byte |
| rec_value | output | 16 | Decoded data value |
| rec_count | output | 8 | Bytes in the frame, saturating |
| rec_simple | output | 1 | Frame held only the command byte |
| rec_bad_op | output | 1 | Command byte had bit 7 clear |

## Verification
The hardest situation to reach is a reset that arrives in the middle of an open frame while chip select stays high. If the monitor reopened the frame on the level alone, the bytes that follow would look like a new command. The bench opens a frame, sends a command and a data byte, pulses reset with chip select still asserted, and then keeps sending bytes before it releases. It expects no record. Right after that it runs a clean frame to show that a fresh assertion is decoded normally. Count saturation is reached by streaming 300 data bytes into one frame.

// File: rtl/nvsram_mon_pkg.sv
package nvsram_mon_pkg;

    localparam int BYTE_W = 8;

    // Opcode keeps bit 7 and the three function bits
    localparam logic [BYTE_W-1:0] OPC_MASK = 8'h87;

    localparam logic [2:0] FN_WRITE   = 3'd3;
    localparam logic [2:0] FN_READ_LO = 3'd6;
    localparam logic [2:0] FN_READ_HI = 3'd7;

    typedef struct packed {
        logic [BYTE_W-1:0] opcode;
        logic [3:0]        addr;
        logic              is_read;
        logic              is_write;
        logic              bad;
    } cmd_info_t;

endpackage

// File: rtl/nvsram_cmd_decode.sv
module nvsram_cmd_decode
    import nvsram_mon_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd_byte,
    output cmd_info_t         info
);

    logic       valid_cmd;
    logic [2:0] fn;

    always_comb begin
        valid_cmd     = cmd_byte[7];
        fn            = cmd_byte[2:0];
        info.opcode   = cmd_byte & OPC_MASK;
        info.addr     = cmd_byte[6:3];
        info.bad      = ~valid_cmd;
        info.is_read  = valid_cmd && ((fn == FN_READ_LO) || (fn == FN_READ_HI));
        info.is_write = valid_cmd && (fn == FN_WRITE);
    end

endmodule

// File: rtl/nvsram_shift_acc.sv
module nvsram_shift_acc
    import nvsram_mon_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              shift,
    input  logic [BYTE_W-1:0] din,
    output logic [DATA_W-1:0] acc_q
);

    localparam int KEEP_W = DATA_W - BYTE_W;

    logic [DATA_W-1:0] acc_d;

    always_comb begin
        acc_d = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (shift) begin
            acc_d = {acc_q[KEEP_W-1:0], din};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/nvsram_frame_seq.sv
module nvsram_frame_seq
    import nvsram_mon_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_active,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] mosi_byte,
    output logic              frame_start,
    output logic              data_shift,
    output logic              frame_end,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic [BYTE_W-1:0] cmd_byte
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic              cs_seen;
        logic              open;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] cmd;
    } seq_t;

    seq_t s_d, s_q;
    logic rise, fall, take, first;
    logic [CNT_W-1:0] base_cnt;

    always_comb begin
        rise     = cs_active && !s_q.cs_seen;
        fall     = !cs_active && s_q.cs_seen;
        take     = cs_active && byte_vld && (s_q.open || rise);
        base_cnt = rise ? '0 : s_q.cnt;
        first    = (base_cnt == '0);

        s_d         = s_q;
        s_d.cs_seen = cs_active;
        if (rise) begin
            s_d.open = 1'b1;
            s_d.cnt  = '0;
        end
        if (fall) begin
            s_d.open = 1'b0;
        end
        if (take) begin
            if (base_cnt != CNT_MAX) begin
                s_d.cnt = base_cnt + 1'b1;
            end
            if (first) begin
                s_d.cmd = mosi_byte;
            end
        end

        frame_start = rise;
        data_shift  = take && !first;
        frame_end   = fall && s_q.open && (s_q.cnt != '0);
        byte_cnt    = s_q.cnt;
        cmd_byte    = s_q.cmd;
    end

    // cs_seen resets high so a level held through reset never opens a frame
    always_ff @(posedge clk) begin
        if (rst) begin
            s_q         <= '0;
            s_q.cs_seen <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/nvsram_frame_mon.sv
module nvsram_frame_mon
    import nvsram_mon_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_active,
    input  logic              byte_vld,
    input  logic [7:0]        mosi_byte,
    input  logic [7:0]        miso_byte,
    output logic              rec_vld,
    output logic [7:0]        rec_opcode,
    output logic [3:0]        rec_addr,
    output logic [DATA_W-1:0] rec_value,
    output logic [CNT_W-1:0]  rec_count,
    output logic              rec_simple,
    output logic              rec_bad_op
);

    localparam int LANES     = 2;
    localparam int LANE_MOSI = 0;
    localparam int LANE_MISO = 1;

    typedef struct packed {
        logic              vld;
        logic [7:0]        opcode;
        logic [3:0]        addr;
        logic [DATA_W-1:0] value;
        logic [CNT_W-1:0]  count;
        logic              simple;
        logic              bad;
    } rec_t;

    logic              frame_start, data_shift, frame_end;
    logic [CNT_W-1:0]  byte_cnt;
    logic [BYTE_W-1:0] cmd_byte;
    cmd_info_t         info;
    logic [DATA_W-1:0] lane_acc [LANES];
    rec_t              rec_d, rec_q;
    logic              only_cmd;

    nvsram_frame_seq #(.CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cs_active   (cs_active),
        .byte_vld    (byte_vld),
        .mosi_byte   (mosi_byte),
        .frame_start (frame_start),
        .data_shift  (data_shift),
        .frame_end   (frame_end),
        .byte_cnt    (byte_cnt),
        .cmd_byte    (cmd_byte)
    );

    nvsram_cmd_decode u_dec (
        .cmd_byte (cmd_byte),
        .info     (info)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        nvsram_shift_acc #(.DATA_W(DATA_W)) u_acc (
            .clk   (clk),
            .rst   (rst),
            .clr   (frame_start),
            .shift (data_shift),
            .din   ((g == LANE_MOSI) ? mosi_byte : miso_byte),
            .acc_q (lane_acc[g])
        );
    end

    always_comb begin
        only_cmd   = (byte_cnt == CNT_W'(1));
        rec_d      = rec_q;
        rec_d.vld  = 1'b0;
        if (frame_end) begin
            rec_d.vld    = 1'b1;
            rec_d.opcode = info.opcode;
            rec_d.bad    = info.bad;
            rec_d.count  = byte_cnt;
            rec_d.simple = only_cmd;
            rec_d.addr   = only_cmd ? 4'd0 : info.addr;
            rec_d.value  = '0;
            if (!only_cmd) begin
                if (info.is_read) begin
                    rec_d.value = lane_acc[LANE_MISO];
                end else if (info.is_write) begin
                    rec_d.value = lane_acc[LANE_MOSI];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end

    assign rec_vld    = rec_q.vld;
    assign rec_opcode = rec_q.opcode;
    assign rec_addr   = rec_q.addr;
    assign rec_value  = rec_q.value;
    assign rec_count  = rec_q.count;
    assign rec_simple = rec_q.simple;
    assign rec_bad_op = rec_q.bad;

endmodule

// File: rtl/nvsram_frame_mon_chk.sv
module nvsram_frame_mon_chk #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_active,
    input logic              rec_vld,
    input logic [7:0]        rec_opcode,
    input logic [3:0]        rec_addr,
    input logic [DATA_W-1:0] rec_value,
    input logic [CNT_W-1:0]  rec_count,
    input logic              rec_simple,
    input logic              rec_bad_op
);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rec_vld |=> !rec_vld);

    a_r8_after_release: assert property (@(posedge clk) disable iff (rst)
        rec_vld |-> (!$past(cs_active) && $past(cs_active, 2)));

    a_r3_masked_opcode: assert property (@(posedge clk) disable iff (rst)
        rec_vld |-> ((rec_opcode & 8'h78) == 8'h00));

    a_r6_simple_fields: assert property (@(posedge clk) disable iff (rst)
        (rec_vld && rec_simple) |-> (rec_addr == 4'd0 && rec_value == '0 && rec_count == CNT_W'(1)));

    a_r6_multi_count: assert property (@(posedge clk) disable iff (rst)
        (rec_vld && !rec_simple) |-> (rec_count >= CNT_W'(2)));

    a_r7_other_zero: assert property (@(posedge clk) disable iff (rst)
        (rec_vld && (rec_bad_op || rec_opcode[2:0] inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd5}))
        |-> (rec_value == '0));

    a_r9_count_nonzero: assert property (@(posedge clk) disable iff (rst)
        rec_vld |-> (rec_count != '0));

    a_r11_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rec_vld);

endmodule

bind nvsram_frame_mon nvsram_frame_mon_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_active  (cs_active),
    .rec_vld    (rec_vld),
    .rec_opcode (rec_opcode),
    .rec_addr   (rec_addr),
    .rec_value  (rec_value),
    .rec_count  (rec_count),
    .rec_simple (rec_simple),
    .rec_bad_op (rec_bad_op)
);

// File: tb/test_nvsram_frame_mon.sv
module test_nvsram_frame_mon;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_active = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  mosi_byte = '0;
    logic [7:0]  miso_byte = '0;
    logic        rec_vld;
    logic [7:0]  rec_opcode;
    logic [3:0]  rec_addr;
    logic [15:0] rec_value;
    logic [7:0]  rec_count;
    logic        rec_simple;
    logic        rec_bad_op;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    nvsram_frame_mon i_nvsram_frame_mon (
        .clk        (clk),
        .rst        (rst),
        .cs_active  (cs_active),
        .byte_vld   (byte_vld),
        .mosi_byte  (mosi_byte),
        .miso_byte  (miso_byte),
        .rec_vld    (rec_vld),
        .rec_opcode (rec_opcode),
        .rec_addr   (rec_addr),
        .rec_value  (rec_value),
        .rec_count  (rec_count),
        .rec_simple (rec_simple),
        .rec_bad_op (rec_bad_op)
    );

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, got, exp);
        end
    endtask

    // Called just after a falling edge; returns after the next one
    task automatic send_byte(input logic [7:0] m, input logic [7:0] s);
        byte_vld  = 1'b1;
        mosi_byte = m;
        miso_byte = s;
        @(negedge clk);
        byte_vld  = 1'b0;
    endtask

    function automatic logic [7:0] mosi_of(input logic [7:0] seed, input int i);
        return seed + 8'(i);
    endfunction

    function automatic logic [7:0] miso_of(input logic [7:0] seed, input int i);
        return (seed + 8'(i)) ^ 8'hA5;
    endfunction

    // Full frame with expected record computed from the requirements
    task automatic run_frame(input string tag, input logic [7:0] cmd, input int ndata,
                             input logic [7:0] seed);
        logic [15:0] e_mosi, e_miso, e_val;
        logic [7:0]  e_opc, e_cnt;
        logic [3:0]  e_addr;
        logic        e_bad, e_simple;
        e_mosi = '0;
        e_miso = '0;
        cs_active = 1'b1;
        @(negedge clk);
        send_byte(cmd, 8'hFF);
        for (int i = 0; i < ndata; i++) begin
            send_byte(mosi_of(seed, i), miso_of(seed, i));
            e_mosi = {e_mosi[7:0], mosi_of(seed, i)};
            e_miso = {e_miso[7:0], miso_of(seed, i)};
        end
        cs_active = 1'b0;
        e_opc    = cmd & 8'h87;
        e_bad    = ~cmd[7];
        e_simple = (ndata == 0);
        e_addr   = e_simple ? 4'd0 : cmd[6:3];
        e_cnt    = (ndata + 1 > 255) ? 8'd255 : 8'(ndata + 1);
        if (e_simple || e_bad)                    e_val = '0;
        else if (e_opc == 8'h86 || e_opc == 8'h87) e_val = e_miso;
        else if (e_opc == 8'h83)                 e_val = e_mosi;
        else                                     e_val = '0;
        @(negedge clk);
        chk({tag, " R8 rec_vld pulse"}, 32'(rec_vld), 32'd1);
        chk({tag, " R3 opcode"}, 32'(rec_opcode), 32'(e_opc));
        chk({tag, " R3 bad flag"}, 32'(rec_bad_op), 32'(e_bad));
        chk({tag, " R4 addr"}, 32'(rec_addr), 32'(e_addr));
        chk({tag, " R6 simple"}, 32'(rec_simple), 32'(e_simple));
        chk({tag, " R5/R7 value"}, 32'(rec_value), 32'(e_val));
        chk({tag, " R9 count"}, 32'(rec_count), 32'(e_cnt));
        @(negedge clk);
        chk({tag, " R8 pulse ends"}, 32'(rec_vld), 32'd0);
        chk({tag, " R8 value held"}, 32'(rec_value), 32'(e_val));
        chk({tag, " R8 count held"}, 32'(rec_count), 32'(e_cnt));
    endtask

    task automatic t_reset_state();
        chk("R11 reset rec_vld", 32'(rec_vld), 32'd0);
        chk("R11 reset value", 32'(rec_value), 32'd0);
        chk("R11 reset count", 32'(rec_count), 32'd0);
        chk("R11 reset opcode", 32'(rec_opcode), 32'd0);
    endtask

    task automatic t_simple_cmds();
        run_frame("write-enable simple", 8'hFC, 0, 8'h00);
        run_frame("sleep simple", 8'h82, 0, 8'h00);
    endtask

    task automatic t_write_read();
        run_frame("write 2B", 8'hAB, 2, 8'h31);
        run_frame("read lo 2B", 8'hD6, 2, 8'h40);
        run_frame("read hi 2B", 8'hFF, 2, 8'h7E);
        run_frame("store 2B value zero", 8'hC1, 2, 8'h12);
        run_frame("recall 2B value zero", 8'h85, 2, 8'h12);
    endtask

    task automatic t_lengths();
        run_frame("write 1B", 8'h9B, 1, 8'hC3);
        run_frame("read 5B keeps last", 8'hB6, 5, 8'h10);
        run_frame("write 300B saturate", 8'h83, 300, 8'h00);
    endtask

    task automatic t_invalid();
        run_frame("invalid op", 8'h3B, 2, 8'h55);
        run_frame("invalid read-shaped op", 8'h7E, 3, 8'h21);
    endtask

    task automatic t_empty_frame();
        cs_active = 1'b1;
        @(negedge clk);
        cs_active = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 empty frame no record", 32'(rec_vld), 32'd0);
        end
    endtask

    task automatic t_ignored_strobes();
        for (int i = 0; i < 3; i++) begin
            send_byte(8'h83, 8'h00);
            chk("R2 idle strobe no record", 32'(rec_vld), 32'd0);
        end
        run_frame("R2 after idle strobes", 8'h83, 2, 8'h66);
    endtask

    task automatic t_reset_mid_frame();
        cs_active = 1'b1;
        @(negedge clk);
        send_byte(8'h83, 8'h00);
        send_byte(8'h11, 8'h22);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11 in-reset rec_vld", 32'(rec_vld), 32'd0);
        send_byte(8'h86, 8'h33);
        send_byte(8'h44, 8'h55);
        cs_active = 1'b0;
        @(negedge clk);
        chk("R11 dropped frame no record", 32'(rec_vld), 32'd0);
        @(negedge clk);
        chk("R1 dropped frame still quiet", 32'(rec_vld), 32'd0);
        run_frame("R1 fresh frame after reset", 8'hE6, 2, 8'h90);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_simple_cmds();
        t_write_read();
        t_lengths();
        t_invalid();
        t_empty_frame();
        t_ignored_strobes();
        t_reset_mid_frame();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule